// File: doc/BRIEF.md
# Serial-to-Parallel Demultiplexer with Loopback Select

This block sits behind a clock-recovery stage. It takes a serial bit stream that is already aligned to a recovered bit clock and turns it into parallel words. A static select input picks the source stream for every bit: the main serial input or a loopback serial input used for system diagnostics. The chosen bit is retimed by one flop and then shifted into a word register, with the earliest bit at the most significant end.

A counter in the bit-clock domain divides the bit clock by the word width, which is 16 by default. It produces a parallel clock with a 50% duty cycle. Each completed word is copied into a holding register on the bit-clock edge where the parallel clock falls. The parallel word therefore stays constant for a full word period and is settled at the next rising edge of the parallel clock. No framing or word alignment is done: word boundaries count from the release of reset.

The reset input `rst_n` is active low and asserts asynchronously. The surrounding logic must release it in step with the bit clock.

Top module: `ser2par_demux`

## Requirements
- R1: While `rst_n` is low, `pword` is all zeros and `pclk_out` is low. Both take these values as soon as reset asserts, without waiting for a clock edge.
- R2: At every bit-clock edge the block samples `din_main` when `sel_loop` is 0 and `din_loop` when `sel_loop` is 1. The input that is not selected has no effect on `pword`.
- R3: A change of `sel_loop` applies from the very next bit-clock edge. The source of each bit is the input named by `sel_loop` at the edge that samples it, even inside a word.
- R4: Counting bit-clock edges e = 1, 2, ... from reset release, `pclk_out` after edge e is 1 when (e mod WORD_W) >= WORD_W/2 and 0 otherwise. This gives a period of WORD_W bits and equal high and low times.
- R5: `pword` changes only on the bit-clock edge where `pclk_out` falls, so it holds for a full WORD_W-bit period.
- R6: Bit ordering is most significant bit first. The bit sampled at edge WORD_W*g+k (k = 0..WORD_W-1) is in `pword[WORD_W-1-k]` of the word that appears after edge WORD_W*(g+1). Nothing else is between them.
- R7: The first word after reset appears after edge WORD_W. Its bit WORD_W-1 is 0, which is the reset value of the retiming flop. Its lower bits are the bits sampled at edges 1 through WORD_W-1.
- R8: A reset in the middle of a stream restarts the divider and the word boundaries. After release, the rules of R4, R6 and R7 apply again, counted from the new release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low reset, asserts asynchronously, released in step with clk_bit |
| din_main | input | 1 | Main serial data input |
| din_loop | input | 1 | Loopback serial data input |
| sel_loop | input | 1 | Source select: 0 picks din_main, 1 picks din_loop |
| pword | output | WORD_W | Parallel word, first-received bit in the MSB |
| pclk_out | output | 1 | Divided parallel clock, bit clock / WORD_W |

## Verification
The bench builds the block with the default WORD_W of 16, so one word period is 16 bit clocks. With this value every divider phase, the wrap of the counter and each change of `pclk_out` occur many times within a few hundred cycles. Its stimulus includes a select input that toggles inside a word, one-hot and all-ones words, and a reset while `pclk_out` is high. These exercise the source switching, the bit ordering, the first word with the reset zero in its top bit, and the restart of the word boundaries.

// File: rtl/ser2par_pkg.sv
package ser2par_pkg;

  // Source selection encoding for the serial input mux
  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_LOOP = 1'b1
  } src_sel_e;

  localparam int unsigned DEF_WORD_W = 16;

endpackage

// File: rtl/s2p_src_retime.sv
module s2p_src_retime
  import ser2par_pkg::*;
(
  input  logic clk_bit,
  input  logic rst_n,
  input  logic din_main,
  input  logic din_loop,
  input  logic sel_loop,
  output logic bit_q
);

  src_sel_e src;
  logic     bit_d;

  assign src = src_sel_e'(sel_loop);

  always_comb begin
    bit_d = din_main;
    if (src == SRC_LOOP) begin
      bit_d = din_loop;
    end
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
    end
  end

endmodule

// File: rtl/s2p_shift.sv
module s2p_shift #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_q,
  output logic [WORD_W-1:0] word_nx
);

  // Next value: every stage takes its lower neighbour, the new bit enters at bit 0
  assign word_nx[0] = bit_in;

  for (genvar gi = 1; gi < WORD_W; gi++) begin : g_stage
    assign word_nx[gi] = word_q[gi-1];
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_nx;
    end
  end

endmodule

// File: rtl/s2p_clkdiv.sv
module s2p_clkdiv #(
  parameter int unsigned WORD_W = 16
) (
  input  logic clk_bit,
  input  logic rst_n,
  output logic pclk_q,
  output logic cap_en
);

  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int unsigned HALF  = WORD_W / 2;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALFC = CNT_W'(HALF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             pclk_nx;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_nx = '0;
    end else begin
      cnt_nx = cnt_q + 1'b1;
    end
    pclk_nx = (cnt_nx >= HALFC);
  end

  // Capture strobe: the edge that wraps the counter is the falling edge of pclk
  assign cap_en = (cnt_q == LAST);

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      pclk_q <= pclk_nx;
    end
  end

endmodule

// File: rtl/s2p_hold.sv
module s2p_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q
);

  logic [WORD_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (cap_en) begin
      word_d = word_in;
    end
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/ser2par_demux.sv
module ser2par_demux
  import ser2par_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              din_main,
  input  logic              din_loop,
  input  logic              sel_loop,
  output logic [WORD_W-1:0] pword,
  output logic              pclk_out
);

  logic              rt_bit;
  logic [WORD_W-1:0] shift_word;
  logic [WORD_W-1:0] shift_next;
  logic              cap_en;

  s2p_src_retime u_src (
    .clk_bit (clk_bit),
    .rst_n   (rst_n),
    .din_main(din_main),
    .din_loop(din_loop),
    .sel_loop(sel_loop),
    .bit_q   (rt_bit)
  );

  s2p_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_bit(clk_bit),
    .rst_n  (rst_n),
    .bit_in (rt_bit),
    .word_q (shift_word),
    .word_nx(shift_next)
  );

  s2p_clkdiv #(.WORD_W(WORD_W)) u_div (
    .clk_bit(clk_bit),
    .rst_n  (rst_n),
    .pclk_q (pclk_out),
    .cap_en (cap_en)
  );

  s2p_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_bit(clk_bit),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .word_in(shift_next),
    .word_q (pword)
  );

endmodule

// File: rtl/ser2par_demux_chk.sv
module ser2par_demux_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_bit,
  input logic              rst_n,
  input logic              din_main,
  input logic              din_loop,
  input logic              sel_loop,
  input logic              sh_lsb,
  input logic [WORD_W-1:0] pword,
  input logic              pclk_out
);

  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALFC = CNT_W'(WORD_W / 2);

  logic [CNT_W-1:0] cyc_q;
  logic [1:0]       warm_q;
  logic             pick;

  assign pick = sel_loop ? din_loop : din_main;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      warm_q <= '0;
    end else begin
      cyc_q  <= (cyc_q == LAST) ? '0 : cyc_q + 1'b1;
      warm_q <= (warm_q == 2'd3) ? warm_q : warm_q + 1'b1;
    end
  end

  // R1: outputs held at their reset values while reset is low
  p_reset_state_r1: assert property (@(posedge clk_bit)
    !rst_n |-> (pword == '0 && !pclk_out));

  // R4: parallel clock phase follows bit edges since reset release
  p_pclk_phase_r4: assert property (@(posedge clk_bit) disable iff (!rst_n)
    pclk_out == (cyc_q >= HALFC));

  // R5: word only moves when pclk falls
  p_word_stable_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !$fell(pclk_out) |-> $stable(pword));

  // R2 / R3: the bit entering the word is the one selected two edges earlier
  p_source_pick_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (sh_lsb == $past(pick, 2)));

endmodule

bind ser2par_demux ser2par_demux_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_bit (clk_bit),
  .rst_n   (rst_n),
  .din_main(din_main),
  .din_loop(din_loop),
  .sel_loop(sel_loop),
  .sh_lsb  (shift_word[0]),
  .pword   (pword),
  .pclk_out(pclk_out)
);

// File: tb/test_ser2par_demux.sv
module test_ser2par_demux;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int HALF       = W / 2;

  logic         clk_bit = 1'b0;
  logic         rst_n;
  logic         din_main;
  logic         din_loop;
  logic         sel_loop;
  logic [W-1:0] pword;
  logic         pclk_out;

  int           n_chk = 0;
  int           n_err = 0;
  int           edge_cnt = 0;
  bit           mon_on = 1'b0;
  string        cur_tag = "R2";
  logic [W-1:0] exp_q[$];
  logic [W-1:0] acc;
  int           pos;
  logic [W-1:0] last_word;

  ser2par_demux #(.WORD_W(W)) i_ser2par_demux (
    .clk_bit (clk_bit),
    .rst_n   (rst_n),
    .din_main(din_main),
    .din_loop(din_loop),
    .sel_loop(sel_loop),
    .pword   (pword),
    .pclk_out(pclk_out)
  );

  always #(CLK_PERIOD/2) clk_bit = ~clk_bit;

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at edge %0d: actual=%h expected=%h", req, edge_cnt, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Expected-word model: bits grouped by bit-edge index since reset release
  task automatic push_bit(input logic b);
    acc[W-1-pos] = b;
    pos++;
    if (pos == W) begin
      exp_q.push_back(acc);
      pos = 0;
      acc = '0;
    end
  endtask

  task automatic stream_start();
    exp_q.delete();
    acc = '0;      // slot 0 of the first word is the retime flop reset value 0 (R7)
    pos = 1;
  endtask

  task automatic drive_word(input logic [W-1:0] m, input logic [W-1:0] l,
                            input logic [W-1:0] s);
    for (int i = W-1; i >= 0; i--) begin
      din_main = m[i];
      din_loop = l[i];
      sel_loop = s[i];
      push_bit(s[i] ? l[i] : m[i]);
      @(negedge clk_bit);
    end
  endtask

  function automatic logic [W-1:0] lfsr_step(input logic [W-1:0] v);
    return {v[W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Bit-edge counter since reset release
  initial begin
    forever begin
      @(posedge clk_bit);
      if (rst_n) edge_cnt++;
    end
  end

  // Monitor / scoreboard
  initial begin
    logic [W-1:0] e;
    forever begin
      @(negedge clk_bit);
      #1;
      if (mon_on) begin
        check(pclk_out == ((edge_cnt % W) >= HALF), "R4", W'(pclk_out),
              W'((edge_cnt % W) >= HALF));
        if (edge_cnt > 0 && (edge_cnt % W) == 0) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 (no expected word)", pword, '0);
          end else begin
            e = exp_q.pop_front();
            check(pword === e, (edge_cnt == W) ? "R7" : cur_tag, pword, e);
          end
        end else begin
          check(pword === last_word, "R5", pword, last_word);
        end
        last_word = pword;
      end
    end
  end

  // Watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    rst_n    = 1'b0;
    din_main = 1'b0;
    din_loop = 1'b0;
    sel_loop = 1'b0;
    repeat (3) @(negedge clk_bit);
    check(pword == '0, "R1", pword, '0);
    check(pclk_out == 1'b0, "R1", W'(pclk_out), '0);

    // Release reset and start the stream
    rst_n = 1'b1;
    edge_cnt = 0;
    stream_start();
    last_word = '0;
    mon_on = 1'b1;

    // R2: main input selected, loopback carries its complement
    cur_tag = "R2";
    r = 16'hACE1;
    for (int k = 0; k < 4; k++) begin
      drive_word(r, ~r, 16'h0000);
      r = lfsr_step(r);
    end
    // R2: loopback selected, main carries all ones
    for (int k = 0; k < 4; k++) begin
      drive_word(16'hFFFF, r, 16'hFFFF);
      r = lfsr_step(r);
    end

    // R3: select toggles inside words; main=1, loop=0 so sampled bit = ~sel
    cur_tag = "R3";
    drive_word(16'hFFFF, 16'h0000, 16'h00FF);
    drive_word(16'hFFFF, 16'h0000, 16'h0F0F);
    drive_word(16'hFFFF, 16'h0000, 16'hAAAA);
    drive_word(16'hFFFF, 16'h0000, 16'h5555);

    // R6: one-hot words expose bit ordering, then all ones
    cur_tag = "R6";
    drive_word(16'h8000, 16'h0000, 16'h0000);
    drive_word(16'h0001, 16'h0000, 16'h0000);
    drive_word(16'h0000, 16'h4000, 16'hFFFF);
    drive_word(16'hFFFF, 16'h0000, 16'h0000);
    drive_word(16'hFFFF, 16'h0000, 16'h0000);

    // Advance ten more bits so pclk is high, then reset mid-stream (R1, R8)
    for (int i = 0; i < 10; i++) begin
      din_main = 1'b1;
      sel_loop = 1'b0;
      push_bit(1'b1);
      @(negedge clk_bit);
    end
    #1;
    check(pclk_out == 1'b1, "R8 (pclk high before reset)", W'(pclk_out), W'(1));
    check(pword == '1, "R6", pword, '1);
    mon_on = 1'b0;
    rst_n = 1'b0;
    #1;
    check(pword == '0, "R1", pword, '0);
    check(pclk_out == 1'b0, "R1", W'(pclk_out), '0);
    repeat (2) @(negedge clk_bit);
    check(pword == '0 && pclk_out == 1'b0, "R1", pword, '0);

    // Restart: boundaries count from the new release
    rst_n = 1'b1;
    edge_cnt = 0;
    stream_start();
    last_word = '0;
    mon_on = 1'b1;
    cur_tag = "R8";
    r = 16'h1D2B;
    for (int k = 0; k < 3; k++) begin
      drive_word(r, ~r, 16'h0FF0);
      r = lfsr_step(r);
    end
    @(negedge clk_bit);
    #2;
    mon_on = 1'b0;
    check(exp_q.size() == 0, "R6 (all words delivered)", W'(exp_q.size()), '0);

    summary();
    $finish;
  end

endmodule